// File: doc/BRIEF.md
# Multi-Queue Packet Buffer with Fast Head and Tail Caches

This block stores fixed-size cells for `NQ` independent FIFO queues. Each queue has a small fast cache on the write side, which holds its newest cells, and a small fast cache on the read side, which holds its oldest cells. Between them sits a wide bulk store that is only ever accessed in blocks of `BLK` cells belonging to one queue. A write-side cache that has gathered a full block gives it up to the bulk store. A read-side cache that runs low is refilled with one block from the bulk store, which returns it `LAT` cycles later. A queue whose cells have never left its write-side cache is read straight from that cache, so a short queue never waits for the bulk store.

The host offers at most one cell write and one read request per cycle. Every read request gets exactly one registered answer on the next cycle: a cell, an "empty queue" error, or a "not yet cached" miss that the host retries. The bulk port takes one block operation per `SLOT` cycles. Reads and writes share that slot, and block writes win. Each queue reports its occupancy and a full flag.

Top module: `mq_cached_buf`

## Requirements
- R1: Within each queue, cells are delivered in exactly the order in which they were accepted, whether they pass through the bulk store or not.
- R2: Each cycle with `rd_req` high produces, on the following cycle, exactly one of `rd_valid`, `rd_err` or `rd_miss`. With no request, all three stay low.
- R3: Traffic on one queue does not alter the contents or the order of any other queue.
- R4: If a queue has an empty read-side cache, nothing in the bulk store and no refill in flight, a read is served from its write-side cache. A cell written in one cycle can therefore be read with `rd_valid` on the very next request.
- R5: The bulk store moves only whole blocks of `BLK` cells of one queue, with at most one block operation in any `SLOT` consecutive cycles. With no reads, a queue accepts exactly `BLK*(NB+3)` cells (28 at the defaults) before it reports full.
- R6: A read of a queue whose read-side cache is empty while its older cells are still in the bulk store or in flight returns `rd_miss`. It delivers no cell and leaves the occupancy unchanged.
- R7: A read of a queue with occupancy 0 returns `rd_err` and changes no state.
- R8: `q_full[q]` is high while the write-side cache of queue q holds `2*BLK` cells. A write to such a queue is discarded and flagged by `wr_drop` on the next cycle.
- R9: `q_occ` field q (bits `q*OCW` upward, `OCW` bits wide) equals the cells accepted minus the cells delivered for queue q.
- R10: If a read of a queue is served from its write-side cache in the same cycle that this queue becomes eligible for a block transfer, or a write to it is accepted in that cycle, the read wins and the transfer waits; no cell is lost or reordered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write one cell this cycle |
| wr_qid | input | $clog2(NQ) | Target queue of the write |
| wr_data | input | DW | Cell written |
| wr_drop | output | 1 | Previous cycle's write was discarded (queue full) |
| rd_req | input | 1 | Read request this cycle |
| rd_qid | input | $clog2(NQ) | Queue to read |
| rd_valid | output | 1 | Previous request delivered `rd_data` |
| rd_data | output | DW | Delivered cell |
| rd_err | output | 1 | Previous request hit an empty queue |
| rd_miss | output | 1 | Previous request found the head not yet cached; retry |
| q_occ | output | NQ*OCW | Per-queue occupancy, queue q in bits `q*OCW +: OCW` |
| q_full | output | NQ | Per-queue full flag |

## Verification
The sharpest overlap arises when a read is served directly from a queue's write-side cache in the same cycle that this cache has just reached a full block and the bulk slot is free, so that a transfer would otherwise take the same oldest cell. The bench provokes this by writing exactly `BLK` cells back to back and then reading that queue on the next cycle. In the following cycles it writes and reads the same queue together, and then drains the queue. A correct run is judged by every delivered cell matching the bench's own per-queue order model and by the occupancy returning to zero. A second overlap, a refill in flight while the reader empties the head cache, is provoked with back-to-back reads of a filled queue. It is judged by a miss that leaves the occupancy unchanged.

// File: rtl/mq_cached_buf_pkg.sv
package mq_cached_buf_pkg;
   // Kind of operation placed on the bulk-store port in a slot
   typedef enum logic [1:0] {
      BOP_NONE  = 2'd0,
      BOP_WRITE = 2'd1,
      BOP_READ  = 2'd2
   } bulk_op_e;
endpackage

// File: rtl/mqb_rr_arb.sv
module mqb_rr_arb #(
   parameter int N  = 4,
   parameter int IW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  req,
   input  logic          adv,
   output logic          any,
   output logic [IW-1:0] idx
);
   logic [IW-1:0] last;

   // search starts one past the last winner, wrapping around
   always_comb begin
      int c;
      any = 1'b0;
      idx = last;
      for (int k = 1; k <= N; k++) begin
         c = (int'(last) + k) % N;
         if (!any && req[c]) begin
            any = 1'b1;
            idx = IW'(c);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)         last <= IW'(N - 1);
      else if (adv && any) last <= idx;
   end
endmodule

// File: rtl/mqb_tail_ring.sv
module mqb_tail_ring #(
   parameter int DW  = 16,
   parameter int BLK = 4,
   parameter int DEP = 8,
   parameter int CW  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [DW-1:0]     din,
   input  logic              pop_one,
   input  logic              pop_blk,
   output logic [CW-1:0]     cnt,
   output logic [DW-1:0]     front,
   output logic [BLK*DW-1:0] blk_out
);
   localparam int PW = $clog2(DEP);

   logic [DW-1:0] mem [DEP];
   logic [PW-1:0] rp, wp;
   logic [CW-1:0] sub;

   always_comb begin
      sub = '0;
      if (pop_one)      sub = CW'(1);
      else if (pop_blk) sub = CW'(BLK);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rp  <= '0;
         wp  <= '0;
         cnt <= '0;
      end else begin
         if (push) wp <= wp + PW'(1);
         rp  <= rp + PW'(sub);
         cnt <= cnt + CW'(push) - sub;
      end
   end

   always_ff @(posedge clk) begin
      if (push) mem[wp] <= din;
   end

   assign front = mem[rp];

   for (genvar i = 0; i < BLK; i++) begin : g_cell
      assign blk_out[i*DW +: DW] = mem[rp + PW'(i)];
   end
endmodule

// File: rtl/mqb_head_ring.sv
module mqb_head_ring #(
   parameter int DW  = 16,
   parameter int BLK = 4,
   parameter int DEP = 8,
   parameter int CW  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_blk,
   input  logic [BLK*DW-1:0] blk_in,
   input  logic              pop_one,
   output logic [CW-1:0]     cnt,
   output logic [DW-1:0]     front
);
   localparam int PW = $clog2(DEP);

   logic [DW-1:0] mem [DEP];
   logic [PW-1:0] rp, wp;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rp  <= '0;
         wp  <= '0;
         cnt <= '0;
      end else begin
         if (push_blk) wp <= wp + PW'(BLK);
         if (pop_one)  rp <= rp + PW'(1);
         cnt <= cnt + (push_blk ? CW'(BLK) : CW'(0)) - CW'(pop_one);
      end
   end

   always_ff @(posedge clk) begin
      if (push_blk) begin
         for (int i = 0; i < BLK; i++) mem[wp + PW'(i)] <= blk_in[i*DW +: DW];
      end
   end

   assign front = mem[rp];
endmodule

// File: rtl/mqb_bulk_store.sv
module mqb_bulk_store #(
   parameter int NQ  = 4,
   parameter int QW  = 2,
   parameter int BW  = 64,
   parameter int NB  = 4,
   parameter int LAT = 6,
   parameter int BCW = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_go,
   input  logic [QW-1:0]           wr_q,
   input  logic [BW-1:0]           wr_blk,
   input  logic                    rd_go,
   input  logic [QW-1:0]           rd_q,
   output logic [NQ-1:0][BCW-1:0]  bcnt,
   output logic                    ret_v,
   output logic [QW-1:0]           ret_q,
   output logic [BW-1:0]           ret_blk
);
   localparam int NBW = $clog2(NB);

   logic [BW-1:0]            mem [NQ*NB];
   logic [NQ-1:0][NBW-1:0]   wp, rp;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp   <= '0;
         rp   <= '0;
         bcnt <= '0;
      end else begin
         for (int q = 0; q < NQ; q++) begin
            if (wr_go && wr_q == QW'(q)) wp[q] <= wp[q] + NBW'(1);
            if (rd_go && rd_q == QW'(q)) rp[q] <= rp[q] + NBW'(1);
            bcnt[q] <= bcnt[q] + BCW'(wr_go && wr_q == QW'(q))
                               - BCW'(rd_go && rd_q == QW'(q));
         end
      end
   end

   always_ff @(posedge clk) begin
      if (wr_go) mem[{wr_q, wp[wr_q]}] <= wr_blk;
   end

   // access latency of the slow store
   if (LAT == 1) begin : g_lat1
      always_ff @(posedge clk) begin
         if (!rst_n) ret_v <= 1'b0;
         else        ret_v <= rd_go;
         ret_q   <= rd_q;
         ret_blk <= mem[{rd_q, rp[rd_q]}];
      end
   end else begin : g_latn
      logic          sv [LAT];
      logic [QW-1:0] sq [LAT];
      logic [BW-1:0] sd [LAT];
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int s = 0; s < LAT; s++) sv[s] <= 1'b0;
         end else begin
            sv[0] <= rd_go;
            for (int s = 1; s < LAT; s++) sv[s] <= sv[s-1];
         end
         sq[0] <= rd_q;
         sd[0] <= mem[{rd_q, rp[rd_q]}];
         for (int s = 1; s < LAT; s++) begin
            sq[s] <= sq[s-1];
            sd[s] <= sd[s-1];
         end
      end
      assign ret_v   = sv[LAT-1];
      assign ret_q   = sq[LAT-1];
      assign ret_blk = sd[LAT-1];
   end
endmodule

// File: rtl/mq_cached_buf.sv
module mq_cached_buf
   import mq_cached_buf_pkg::*;
#(
   parameter int NQ   = 4,
   parameter int DW   = 16,
   parameter int BLK  = 4,
   parameter int NB   = 4,
   parameter int SLOT = 4,
   parameter int LAT  = 6,
   localparam int QW  = $clog2(NQ),
   localparam int OCW = $clog2(4*BLK + NB*BLK + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [QW-1:0]     wr_qid,
   input  logic [DW-1:0]     wr_data,
   output logic              wr_drop,
   input  logic              rd_req,
   input  logic [QW-1:0]     rd_qid,
   output logic              rd_valid,
   output logic [DW-1:0]     rd_data,
   output logic              rd_err,
   output logic              rd_miss,
   output logic [NQ*OCW-1:0] q_occ,
   output logic [NQ-1:0]     q_full
);
   localparam int TDEP = 2*BLK;
   localparam int HDEP = 2*BLK;
   localparam int TCW  = $clog2(TDEP + 1);
   localparam int HCW  = $clog2(HDEP + 1);
   localparam int BCW  = $clog2(NB + 1);
   localparam int SCW  = $clog2(SLOT + 1);
   localparam int BW   = BLK*DW;

   // elaboration-time parameter checks
   if (NQ < 2)                    begin : g_bad_nq   $error("NQ must be at least 2");            end
   if (BLK < 2 || (BLK & (BLK-1)) != 0) begin : g_bad_blk $error("BLK must be a power of two >= 2"); end
   if (NB < 2 || (NB & (NB-1)) != 0)    begin : g_bad_nb  $error("NB must be a power of two >= 2");  end
   if (SLOT < BLK)                begin : g_bad_slot $error("SLOT must be at least BLK");       end
   if (LAT < 1)                   begin : g_bad_lat  $error("LAT must be at least 1");          end

   logic [NQ-1:0][TCW-1:0] tcnt;
   logic [NQ-1:0][HCW-1:0] hcnt;
   logic [NQ-1:0][BCW-1:0] bcnt;
   logic [NQ-1:0][OCW-1:0] occ;
   logic [NQ-1:0]          pend;
   logic [DW-1:0]          tfront [NQ];
   logic [DW-1:0]          hfront [NQ];
   logic [BW-1:0]          tblk   [NQ];

   logic                   ret_v;
   logic [QW-1:0]          ret_q;
   logic [BW-1:0]          ret_blk;

   // ---------------- request decode ----------------
   logic wr_acc, rq_empty, hit_head, hit_tail, rd_hit, miss;

   assign wr_acc   = wr_en && (tcnt[wr_qid] != TCW'(TDEP));
   assign rq_empty = (occ[rd_qid] == '0);
   assign hit_head = rd_req && !rq_empty && (hcnt[rd_qid] != '0);
   assign hit_tail = rd_req && !rq_empty && (hcnt[rd_qid] == '0) &&
                     (bcnt[rd_qid] == '0) && !pend[rd_qid] && (tcnt[rd_qid] != '0);
   assign rd_hit   = hit_head || hit_tail;
   assign miss     = rd_req && !rq_empty && !rd_hit;

   // ---------------- bulk slot scheduling ----------------
   logic [NQ-1:0] elig_w, elig_r;
   logic          any_w, any_r, slot_free, wgo, rgo, bop_any;
   logic [QW-1:0] wq, rq;
   logic [SCW-1:0] slot_cnt;
   bulk_op_e      bop;

   always_comb begin
      for (int q = 0; q < NQ; q++) begin
         // a bypass read of this queue this cycle owns its oldest cell
         elig_w[q] = (tcnt[q] >= TCW'(BLK)) && (bcnt[q] != BCW'(NB)) &&
                     !(hit_tail && rd_qid == QW'(q));
         elig_r[q] = (hcnt[q] < HCW'(BLK)) && (bcnt[q] != '0) && !pend[q];
      end
   end

   assign slot_free = (slot_cnt == '0);

   always_comb begin
      bop = BOP_NONE;
      if (slot_free) begin
         if (any_w)      bop = BOP_WRITE;
         else if (any_r) bop = BOP_READ;
      end
   end

   assign wgo     = (bop == BOP_WRITE);
   assign rgo     = (bop == BOP_READ);
   assign bop_any = wgo || rgo;

   mqb_rr_arb #(.N(NQ), .IW(QW)) u_warb (
      .clk(clk), .rst_n(rst_n), .req(elig_w), .adv(wgo), .any(any_w), .idx(wq)
   );

   mqb_rr_arb #(.N(NQ), .IW(QW)) u_rarb (
      .clk(clk), .rst_n(rst_n), .req(elig_r), .adv(rgo), .any(any_r), .idx(rq)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)        slot_cnt <= '0;
      else if (bop_any)  slot_cnt <= SCW'(SLOT - 1);
      else if (!slot_free) slot_cnt <= slot_cnt - SCW'(1);
   end

   // ---------------- per-queue caches ----------------
   for (genvar q = 0; q < NQ; q++) begin : g_q
      mqb_tail_ring #(.DW(DW), .BLK(BLK), .DEP(TDEP), .CW(TCW)) u_tail (
         .clk     (clk),
         .rst_n   (rst_n),
         .push    (wr_acc && wr_qid == QW'(q)),
         .din     (wr_data),
         .pop_one (hit_tail && rd_qid == QW'(q)),
         .pop_blk (wgo && wq == QW'(q)),
         .cnt     (tcnt[q]),
         .front   (tfront[q]),
         .blk_out (tblk[q])
      );

      mqb_head_ring #(.DW(DW), .BLK(BLK), .DEP(HDEP), .CW(HCW)) u_head (
         .clk      (clk),
         .rst_n    (rst_n),
         .push_blk (ret_v && ret_q == QW'(q)),
         .blk_in   (ret_blk),
         .pop_one  (hit_head && rd_qid == QW'(q)),
         .cnt      (hcnt[q]),
         .front    (hfront[q])
      );

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pend[q] <= 1'b0;
            occ[q]  <= '0;
         end else begin
            if (rgo && rq == QW'(q))             pend[q] <= 1'b1;
            else if (ret_v && ret_q == QW'(q))   pend[q] <= 1'b0;
            occ[q] <= occ[q] + OCW'(wr_acc && wr_qid == QW'(q))
                             - OCW'(rd_hit && rd_qid == QW'(q));
         end
      end

      assign q_full[q] = (tcnt[q] == TCW'(TDEP));
   end

   // ---------------- wide slow store ----------------
   mqb_bulk_store #(.NQ(NQ), .QW(QW), .BW(BW), .NB(NB), .LAT(LAT), .BCW(BCW)) u_bulk (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_go   (wgo),
      .wr_q    (wq),
      .wr_blk  (tblk[wq]),
      .rd_go   (rgo),
      .rd_q    (rq),
      .bcnt    (bcnt),
      .ret_v   (ret_v),
      .ret_q   (ret_q),
      .ret_blk (ret_blk)
   );

   // ---------------- registered responses ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_err   <= 1'b0;
         rd_miss  <= 1'b0;
         wr_drop  <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= rd_hit;
         rd_err   <= rd_req && rq_empty;
         rd_miss  <= miss;
         wr_drop  <= wr_en && !wr_acc;
         if (rd_hit) rd_data <= hit_head ? hfront[rd_qid] : tfront[rd_qid];
      end
   end

   assign q_occ = occ;
endmodule

// File: rtl/mq_cached_buf_chk.sv
module mq_cached_buf_chk #(
   parameter int NQ  = 4,
   parameter int QW  = 2,
   parameter int BLK = 4,
   parameter int SLOT = 4,
   parameter int OCW = 6,
   parameter int TCW = 4,
   parameter int HCW = 4,
   parameter int BCW = 3
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   wr_en,
   input logic [QW-1:0]          wr_qid,
   input logic                   wr_drop,
   input logic                   rd_req,
   input logic [QW-1:0]          rd_qid,
   input logic                   rd_valid,
   input logic                   rd_err,
   input logic                   rd_miss,
   input logic [NQ-1:0]          q_full,
   input logic [NQ-1:0][OCW-1:0] occ,
   input logic [NQ-1:0][TCW-1:0] tcnt,
   input logic [NQ-1:0][HCW-1:0] hcnt,
   input logic [NQ-1:0][BCW-1:0] bcnt,
   input logic [NQ-1:0]          pend,
   input logic                   bop_any
);
   // R2: at most one kind of answer per cycle
   a_r2_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rd_valid, rd_err, rd_miss}));

   // R2: every request is answered on the next cycle
   a_r2_reply: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> (rd_valid || rd_err || rd_miss));

   // R7: empty queue read is refused
   a_r7_empty_err: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && occ[rd_qid] == '0) |=> rd_err);

   // R6: head not cached while older cells sit in the bulk store
   a_r6_miss: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && hcnt[rd_qid] == '0 && bcnt[rd_qid] != '0) |=> rd_miss);

   // R8: write to a full queue is dropped
   a_r8_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && q_full[wr_qid]) |=> wr_drop);

   // R5: bulk port gap between block operations
   if (SLOT > 1) begin : g_gap
      a_r5_slot_gap: assert property (@(posedge clk) disable iff (!rst_n)
         bop_any |=> !bop_any);
   end

   for (genvar q = 0; q < NQ; q++) begin : g_inv
      // R9: occupancy counter agrees with the cells held in every stage
      a_r9_occ_sum: assert property (@(posedge clk) disable iff (!rst_n)
         32'(occ[q]) == 32'(tcnt[q]) + 32'(hcnt[q]) + BLK*(32'(bcnt[q]) + 32'(pend[q])));
      // R8: write-side cache never exceeds its depth
      a_r8_tail_bound: assert property (@(posedge clk) disable iff (!rst_n)
         32'(tcnt[q]) <= 2*BLK);
   end
endmodule

bind mq_cached_buf mq_cached_buf_chk #(
   .NQ(NQ), .QW(QW), .BLK(BLK), .SLOT(SLOT), .OCW(OCW), .TCW(TCW), .HCW(HCW), .BCW(BCW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_qid(wr_qid), .wr_drop(wr_drop),
   .rd_req(rd_req), .rd_qid(rd_qid), .rd_valid(rd_valid), .rd_err(rd_err),
   .rd_miss(rd_miss), .q_full(q_full), .occ(occ), .tcnt(tcnt), .hcnt(hcnt),
   .bcnt(bcnt), .pend(pend), .bop_any(bop_any)
);

// File: tb/mq_cached_buf_tb.sv
`timescale 1ns/1ps
module mq_cached_buf_tb;
   localparam int NQ  = 4;
   localparam int QW  = 2;
   localparam int DW  = 16;
   localparam int OCW = 6;
   localparam int CAP = 28;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [QW-1:0]     wr_qid = '0;
   logic [DW-1:0]     wr_data = '0;
   logic              wr_drop;
   logic              rd_req = 1'b0;
   logic [QW-1:0]     rd_qid = '0;
   logic              rd_valid;
   logic [DW-1:0]     rd_data;
   logic              rd_err;
   logic              rd_miss;
   logic [NQ*OCW-1:0] q_occ;
   logic [NQ-1:0]     q_full;

   int nchk = 0;
   int nfail = 0;
   logic [DW-1:0] mdat [NQ][64];
   int mw [NQ];
   int mr [NQ];
   int seq = 0;

   always #2 clk = ~clk;

   mq_cached_buf u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_qid(wr_qid), .wr_data(wr_data),
      .wr_drop(wr_drop), .rd_req(rd_req), .rd_qid(rd_qid), .rd_valid(rd_valid),
      .rd_data(rd_data), .rd_err(rd_err), .rd_miss(rd_miss), .q_occ(q_occ), .q_full(q_full)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int occ_of(input int q);
      return int'(q_occ[q*OCW +: OCW]);
   endfunction

   task automatic cyc();
      @(posedge clk);
      @(negedge clk);
   endtask

   function automatic logic [DW-1:0] mk(input int q);
      seq++;
      return DW'((q << 12) | (seq & 12'hfff));
   endfunction

   // one write; returns whether it was dropped
   task automatic do_wr(input int q, output bit dropped);
      logic [DW-1:0] d;
      d = mk(q);
      wr_en = 1'b1; wr_qid = QW'(q); wr_data = d;
      cyc();
      wr_en = 1'b0;
      dropped = wr_drop;
      if (!dropped) begin mdat[q][mw[q] % 64] = d; mw[q]++; end
   endtask

   // one read; res 0 = cell, 1 = miss, 2 = error
   task automatic do_rd(input int q, input string tag, output int res);
      rd_req = 1'b1; rd_qid = QW'(q);
      cyc();
      rd_req = 1'b0;
      if (rd_valid) begin
         res = 0;
         chk(mw[q] != mr[q], {tag, " cell from empty model"}, int'(rd_data), -1);
         chk(rd_data == mdat[q][mr[q] % 64], {tag, " R1 order"}, int'(rd_data),
             int'(mdat[q][mr[q] % 64]));
         mr[q]++;
      end else if (rd_miss) res = 1;
      else res = 2;
      chk(int'(rd_valid) + int'(rd_miss) + int'(rd_err) == 1, {tag, " R2 one answer"},
          int'(rd_valid) + int'(rd_miss) + int'(rd_err), 1);
   endtask

   task automatic rd_retry(input int q, input string tag);
      int res;
      res = 1;
      for (int t = 0; t < 40 && res == 1; t++) do_rd(q, tag, res);
      chk(res == 0, {tag, " R1 cell eventually delivered"}, res, 0);
   endtask

   task automatic t_reset();
      chk(q_occ == '0, "R9 occupancy after reset", int'(q_occ), 0);
      chk(q_full == '0, "R8 full after reset", int'(q_full), 0);
      chk(!rd_valid && !rd_err && !rd_miss, "R2 idle after reset",
          int'({rd_valid, rd_err, rd_miss}), 0);
   endtask

   task automatic t_empty();
      int res;
      do_rd(1, "R7 empty", res);
      chk(res == 2, "R7 empty read flagged", res, 2);
      chk(occ_of(1) == 0, "R7 occupancy untouched", occ_of(1), 0);
      cyc();
      chk(!rd_valid && !rd_err && !rd_miss, "R2 no answer without request",
          int'({rd_valid, rd_err, rd_miss}), 0);
   endtask

   task automatic t_bypass();
      bit dr;
      int res;
      do_wr(2, dr);
      chk(!dr, "R4 write accepted", int'(dr), 0);
      chk(occ_of(2) == 1, "R9 occupancy one", occ_of(2), 1);
      do_rd(2, "R4 bypass", res);
      chk(res == 0, "R4 first read served", res, 0);
      chk(occ_of(2) == 0, "R9 occupancy back to zero", occ_of(2), 0);
   endtask

   task automatic t_interleave();
      bit dr;
      for (int i = 0; i < 10; i++) begin
         do_wr(1 + (i % 2), dr);
         repeat (2) cyc();
      end
      repeat (12) cyc();
      chk(occ_of(1) == 5 && occ_of(2) == 5, "R3 per-queue counts", occ_of(1), 5);
      for (int i = 0; i < 10; i++) rd_retry(1 + ((i + 1) % 2), "R3 interleave");
      chk(occ_of(1) == 0 && occ_of(2) == 0, "R3 queues drained", occ_of(2), 0);
   endtask

   // same-cycle bypass read against a full block in the write cache
   task automatic t_collide();
      bit dr;
      logic [DW-1:0] d;
      int res;
      for (int i = 0; i < 4; i++) do_wr(3, dr);
      for (int i = 0; i < 4; i++) begin
         d = mk(3);
         wr_en = 1'b1; wr_qid = 2'd3; wr_data = d;
         rd_req = 1'b1; rd_qid = 2'd3;
         cyc();
         wr_en = 1'b0; rd_req = 1'b0;
         chk(!wr_drop, "R10 concurrent write accepted", int'(wr_drop), 0);
         if (!wr_drop) begin mdat[3][mw[3] % 64] = d; mw[3]++; end
         chk(rd_valid, "R10 concurrent read served", int'(rd_valid), 1);
         if (rd_valid) begin
            chk(rd_data == mdat[3][mr[3] % 64], "R10 order under collision",
                int'(rd_data), int'(mdat[3][mr[3] % 64]));
            mr[3]++;
         end
      end
      for (int i = 0; i < 4; i++) rd_retry(3, "R10 tail drain");
      chk(occ_of(3) == 0, "R10 occupancy zero", occ_of(3), 0);
      do_rd(3, "R10 final", res);
      chk(res == 2, "R7 drained queue reports empty", res, 2);
   endtask

   task automatic t_fill_drain();
      bit dr;
      int acc, res;
      acc = 0;
      for (int i = 0; i < CAP; i++) begin
         do_wr(0, dr);
         if (!dr) acc++;
         repeat (8) cyc();
      end
      chk(acc == CAP, "R5 cells accepted before full", acc, CAP);
      chk(q_full[0], "R8 full flag raised", int'(q_full[0]), 1);
      chk(occ_of(0) == CAP, "R9 occupancy at capacity", occ_of(0), CAP);
      do_wr(0, dr);
      chk(dr, "R8 extra write dropped", int'(dr), 1);
      chk(occ_of(0) == CAP, "R8 occupancy unchanged by drop", occ_of(0), CAP);
      for (int i = 0; i < 4; i++) do_rd(0, "R6 head", res);
      do_rd(0, "R6 head empty", res);
      chk(res == 1, "R6 miss while refill in flight", res, 1);
      chk(occ_of(0) == CAP - 4, "R6 miss leaves occupancy", occ_of(0), CAP - 4);
      for (int i = 0; i < CAP - 4; i++) rd_retry(0, "R1 drain");
      chk(occ_of(0) == 0, "R9 drained", occ_of(0), 0);
      chk(!q_full[0], "R8 full cleared", int'(q_full[0]), 0);
   endtask

   initial begin
      for (int q = 0; q < NQ; q++) begin mw[q] = 0; mr[q] = 0; end
      repeat (3) cyc();
      rst_n = 1'b1;
      cyc();
      t_reset();
      t_empty();
      t_bypass();
      t_interleave();
      t_collide();
      t_fill_drain();
      repeat (4) cyc();
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      nchk++;
      nfail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule